// File: doc/BRIEF.md
# Receive FIFO Status and Flow-Control Unit

This unit sits between a serial receiver's character assembler and the host's register interface. Each character comes in with three error flags: break, framing and parity. The unit stores the character and its flags in a small first-in first-out buffer, and a host data read removes the oldest entry. The unit reports error status in one of two ways. In per-character mode the flags belong to the oldest stored character. In accumulating mode they are the sticky OR of the flags of every character that has become the oldest entry since the last clear command.

The unit also drives the receive interrupt, taken from one of two sources. Its third job is the active-low request-to-send line that throttles the remote transmitter. When receive flow control is enabled, a start bit seen while the buffer is full raises the line. The line drops again as soon as a slot is free. A 4-bit configuration register, written by a strobe, selects these behaviours. It clears to zero on reset.

Top module: `rxq_status_unit`

## Requirements
- R1: After reset the configuration is all zeros. rtsN is low, rxReady, fifoFull, irq and overrun are low, and the three status outputs are low.
- R2: Up to DEPTH (default 4) characters are held. A pulse on hostRead removes the oldest one, and rdData shows the oldest character (zero when empty). Characters leave in the order they arrived, and a read while empty changes nothing. rxReady is high when at least one character is stored, and fifoFull is high when DEPTH characters are stored.
- R3: A character offered while fifoFull is high is discarded. This happens even if a read occurs in the same cycle. The buffer contents are left unchanged and overrun becomes 1 on the next cycle and stays 1.
- R4: With cfgIn bit 0 clear (per-character mode), stBreak, stFrame and stParity equal the flags stored with the oldest character, and are zero when the buffer is empty.
- R5: With cfgIn bit 0 set (accumulating mode), the three status outputs are the OR of the flags of every character that has become the oldest entry since reset or the last clear command. A character becomes the oldest entry when it is written into an empty buffer, or when a read exposes it.
- R6: A clrErrors pulse clears the accumulated flags and overrun in one cycle. If a character becomes the oldest entry in that same cycle, its flags are kept as the first ones accumulated. A discard in that same cycle still sets overrun.
- R7: With cfgIn bit 1 clear, irq equals rxReady. With it set, irq equals fifoFull.
- R8: With receive flow control active, a startBit pulse while fifoFull is high drives rtsN high on the next cycle.
- R9: With receive flow control active, once rtsN is high and fifoFull is low, rtsN returns low on the next cycle. Without a new start bit while the buffer is full, rtsN stays low.
- R10: With cfgIn bit 2 (receive flow control) clear, start bits have no effect, and rtsN is low from the next cycle on.
- R11: With cfgIn bit 3 (transmit flow control) set, receive flow control is inactive even when bit 2 is set, and rtsN behaves as in R10.
- R12: A cfgWe pulse loads cfgIn into the configuration register. The new setting governs irq and the status outputs from the next cycle, and governs the request-to-send update from the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | A received character is offered this cycle |
| charData | input | 8 | Received character |
| charBreak | input | 1 | Break flag of the offered character |
| charFrame | input | 1 | Framing-error flag of the offered character |
| charParity | input | 1 | Parity-error flag of the offered character |
| startBit | input | 1 | Valid start bit detected strobe |
| hostRead | input | 1 | Host data read strobe; removes the oldest character |
| clrErrors | input | 1 | Clear-error-status command strobe |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIn | input | 4 | Configuration: bit0 accumulating mode, bit1 irq on full, bit2 receive flow control, bit3 transmit flow control |
| rdData | output | 8 | Oldest stored character |
| rxReady | output | 1 | Buffer not empty |
| fifoFull | output | 1 | Buffer full |
| stBreak | output | 1 | Break status |
| stFrame | output | 1 | Framing-error status |
| stParity | output | 1 | Parity-error status |
| overrun | output | 1 | Sticky discarded-character flag |
| irq | output | 1 | Receive interrupt |
| rtsN | output | 1 | Active-low request to send |

## Verification
The assertions assume that every input is synchronous and changes only between rising edges. They also assume that the flow-control and status properties may look one cycle ahead only when no configuration write lands in that cycle, which is why the clear-command property requires cfgWe to be low. The stimulus drives all inputs at the falling edge and writes the configuration only at the start of each sweep step, so every property sees stable settings. It sweeps all sixteen configurations with alternating fill and drain phases. This forces the buffer through full, overrun, start-bit-while-full and clear-during-arrival cases in every mode.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } errFlags_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    errFlags_t         flags;
  } rxEntry_t;

  // bit0 blockMode, bit1 irqOnFull, bit2 rxFlow, bit3 txFlow
  typedef struct packed {
    logic txFlow;
    logic rxFlow;
    logic irqOnFull;
    logic blockMode;
  } rxCfg_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic topArrive;
    logic arriveFromInput;
    logic clrAcc;
    logic setOverrun;
  } ctlStrobe_t;
endpackage

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             charValid,
  input  logic             hostRead,
  input  logic             startBit,
  input  logic             clrErrors,
  input  logic             cfgWe,
  input  rxCfg_t           cfgIn,
  output ctlStrobe_t       ctl,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             empty,
  output logic             full,
  output rxCfg_t           cfgQ,
  output logic             rtsN
);
  logic [CNT_W-1:0] count;
  logic             flowActive;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign flowActive = cfgQ.rxFlow && !cfgQ.txFlow;

  always_comb begin
    ctl.push            = charValid && !full;
    ctl.pop             = hostRead && !empty;
    ctl.arriveFromInput = (count <= CNT_W'(1));
    ctl.topArrive       = (ctl.push && empty)
                        || (ctl.pop && count >= CNT_W'(2))
                        || (ctl.pop && ctl.push && count == CNT_W'(1));
    ctl.clrAcc          = clrErrors;
    ctl.setOverrun      = charValid && full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + 1'b1;
      if (ctl.pop)  rdPtr <= rdPtr + 1'b1;
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgQ <= '0;
    end else if (cfgWe) begin
      cfgQ <= cfgIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rtsN <= 1'b0;
    end else if (!flowActive) begin
      rtsN <= 1'b0;
    end else if (startBit && full) begin
      rtsN <= 1'b1;
    end else if (rtsN && !full) begin
      rtsN <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        ctl,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic              empty,
  input  rxEntry_t          inEntry,
  input  logic              blockMode,
  output logic [DATA_W-1:0] outData,
  output errFlags_t         outFlags,
  output logic              overrunQ
);
  rxEntry_t         mem [DEPTH];
  errFlags_t        acc;
  errFlags_t        arriveFlags;
  errFlags_t        gated;
  logic [PTR_W-1:0] nextPtr;
  rxEntry_t         head;

  assign nextPtr     = rdPtr + 1'b1;
  assign head        = mem[rdPtr];
  assign arriveFlags = ctl.arriveFromInput ? inEntry.flags : mem[nextPtr].flags;
  assign gated       = ctl.topArrive ? arriveFlags : '0;

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= inEntry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      overrunQ <= 1'b0;
    end else begin
      acc <= ctl.clrAcc ? gated : (acc | gated);
      if (ctl.setOverrun)  overrunQ <= 1'b1;
      else if (ctl.clrAcc) overrunQ <= 1'b0;
    end
  end

  always_comb begin
    outData = empty ? '0 : head.data;
    if (blockMode)  outFlags = acc;
    else if (empty) outFlags = '0;
    else            outFlags = head.flags;
  end
endmodule

// File: rtl/rxq_status_unit.sv
module rxq_status_unit
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              charBreak,
  input  logic              charFrame,
  input  logic              charParity,
  input  logic              startBit,
  input  logic              hostRead,
  input  logic              clrErrors,
  input  logic              cfgWe,
  input  logic [3:0]        cfgIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rxReady,
  output logic              fifoFull,
  output logic              stBreak,
  output logic              stFrame,
  output logic              stParity,
  output logic              overrun,
  output logic              irq,
  output logic              rtsN
);
  ctlStrobe_t       ctl;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             empty;
  rxCfg_t           cfgQ;
  rxEntry_t         inEntry;
  errFlags_t        outFlags;

  assign inEntry = '{data: charData, flags: '{brk: charBreak, frm: charFrame, par: charParity}};

  rxq_control #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .charValid(charValid), .hostRead(hostRead),
    .startBit(startBit), .clrErrors(clrErrors), .cfgWe(cfgWe), .cfgIn(rxCfg_t'(cfgIn)),
    .ctl(ctl), .wrPtr(wrPtr), .rdPtr(rdPtr), .empty(empty), .full(fifoFull),
    .cfgQ(cfgQ), .rtsN(rtsN)
  );

  rxq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .empty(empty), .inEntry(inEntry), .blockMode(cfgQ.blockMode),
    .outData(rdData), .outFlags(outFlags), .overrunQ(overrun)
  );

  assign rxReady  = !empty;
  assign stBreak  = outFlags.brk;
  assign stFrame  = outFlags.frm;
  assign stParity = outFlags.par;
  assign irq      = cfgQ.irqOnFull ? fifoFull : rxReady;
endmodule

// File: rtl/rxq_status_checker.sv
module rxq_status_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       charValid,
  input logic       startBit,
  input logic       hostRead,
  input logic       clrErrors,
  input logic       cfgWe,
  input logic [3:0] cfgBits,
  input logic       fifoFull,
  input logic       rxReady,
  input logic       stBreak,
  input logic       stFrame,
  input logic       stParity,
  input logic       overrun,
  input logic       irq,
  input logic       rtsN
);
  logic flowOn;
  assign flowOn = cfgBits[2] && !cfgBits[3];

  p_full_implies_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifoFull |-> rxReady);

  p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (charValid && fifoFull) |=> overrun);

  p_clear_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgBits[0] && !cfgWe && clrErrors && !charValid && !hostRead)
      |=> (!stBreak && !stFrame && !stParity && !overrun));

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (cfgBits[1] ? fifoFull : rxReady));

  p_rts_negate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flowOn && startBit && fifoFull) |=> rtsN);

  p_rts_reassert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flowOn && rtsN && !fifoFull) |=> !rtsN);

  p_rts_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flowOn |=> !rtsN);
endmodule

bind rxq_status_unit rxq_status_checker u_chk (
  .clk(clk), .rst_n(rst_n), .charValid(charValid), .startBit(startBit),
  .hostRead(hostRead), .clrErrors(clrErrors), .cfgWe(cfgWe), .cfgBits(cfgQ),
  .fifoFull(fifoFull), .rxReady(rxReady), .stBreak(stBreak), .stFrame(stFrame),
  .stParity(stParity), .overrun(overrun), .irq(irq), .rtsN(rtsN)
);

// File: tb/rxq_status_unit_test.sv
module rxq_status_unit_test;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       charValid = 0, charBreak = 0, charFrame = 0, charParity = 0;
  logic [7:0] charData = '0;
  logic       startBit = 0, hostRead = 0, clrErrors = 0, cfgWe = 0;
  logic [3:0] cfgIn = '0;
  logic [7:0] rdData;
  logic       rxReady, fifoFull, stBreak, stFrame, stParity, overrun, irq, rtsN;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [10:0] mq[$];
  logic [2:0]  mAcc = '0;
  logic        mOv = 0, mRts = 0;
  logic [3:0]  mCfg = '0;

  always #10 clk = ~clk;

  rxq_status_unit #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .charValid(charValid), .charData(charData),
    .charBreak(charBreak), .charFrame(charFrame), .charParity(charParity),
    .startBit(startBit), .hostRead(hostRead), .clrErrors(clrErrors),
    .cfgWe(cfgWe), .cfgIn(cfgIn), .rdData(rdData), .rxReady(rxReady),
    .fifoFull(fifoFull), .stBreak(stBreak), .stFrame(stFrame),
    .stParity(stParity), .overrun(overrun), .irq(irq), .rtsN(rtsN)
  );

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(input logic clrNow);
    logic ready, full;
    logic [7:0] d;
    logic [2:0] f;
    ready = (mq.size() > 0);
    full  = (mq.size() == DEPTH);
    d = ready ? mq[0][10:3] : 8'h00;
    f = mCfg[0] ? mAcc : (ready ? mq[0][2:0] : 3'b000);
    chk("R2 rdData", 11'(rdData), 11'(d));
    chk("R2 rxReady/fifoFull", 11'({rxReady, fifoFull}), 11'({ready, full}));
    chk(clrNow ? "R3 R6 overrun" : "R3 overrun", 11'(overrun), 11'(mOv));
    if (mCfg[0]) chk(clrNow ? "R5 R6 status" : "R5 status", 11'({stBreak, stFrame, stParity}), 11'(f));
    else         chk("R4 status", 11'({stBreak, stFrame, stParity}), 11'(f));
    chk("R7 R12 irq", 11'(irq), 11'(mCfg[1] ? full : ready));
    if (mCfg[2] && !mCfg[3]) chk("R8 R9 rtsN", 11'(rtsN), 11'(mRts));
    else                     chk("R10 R11 rtsN", 11'(rtsN), 11'(mRts));
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic [2:0] f,
                      input logic st, input logic rd, input logic clr,
                      input logic we, input logic [3:0] cv);
    logic full, wasEmpty, pushOk, popOk, arrived;
    logic [2:0] af;
    @(negedge clk);
    charValid = v; charData = d; {charBreak, charFrame, charParity} = f;
    startBit = st; hostRead = rd; clrErrors = clr; cfgWe = we; cfgIn = cv;
    full = (mq.size() == DEPTH);
    wasEmpty = (mq.size() == 0);
    pushOk = v && !full;
    popOk  = rd && !wasEmpty;
    if (popOk) void'(mq.pop_front());
    if (pushOk) mq.push_back({d, f});
    arrived = (mq.size() > 0) && (popOk || wasEmpty);
    af = arrived ? mq[0][2:0] : 3'b000;
    mAcc = clr ? af : (mAcc | af);
    mOv = (clr ? 1'b0 : mOv) | (v && full);
    if (!(mCfg[2] && !mCfg[3])) mRts = 1'b0;
    else if (st && full)        mRts = 1'b1;
    else if (mRts && !full)     mRts = 1'b0;
    if (we) mCfg = cv;
    @(posedge clk);
    #1;
    compareAll(clr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 reset outputs", 11'({rxReady, fifoFull, irq, overrun, rtsN, stBreak, stFrame, stParity}), 11'd0);
    chk("R1 reset rdData", 11'(rdData), 11'd0);
    // R2: read while empty has no effect
    step(0, 8'h00, 3'b000, 0, 1, 0, 0, 4'h0);
    // R3/R8: fill, overrun, start bit while full under rx flow control
    step(0, 8'h00, 3'b000, 0, 0, 0, 1, 4'b0101);
    for (int k = 0; k < 6; k++) step(1, 8'(8'h30 + k), 3'(k), 1, 0, 0, 0, 4'h0);
    step(0, 8'h00, 3'b000, 0, 1, 1, 0, 4'h0);
    step(0, 8'h00, 3'b000, 0, 0, 0, 0, 4'h0);
    // R11: both flow controls set, start bits while full ignored
    step(0, 8'h00, 3'b000, 0, 0, 0, 1, 4'b1100);
    for (int k = 0; k < 3; k++) step(1, 8'hA0, 3'b111, 1, 0, 0, 0, 4'h0);
    // Sweep all configurations
    for (int c = 0; c < 16; c++) begin
      step(0, 8'h00, 3'b000, 0, 0, 0, 1, 4'(c));
      for (int i = 0; i < 400; i++) begin
        logic fillPhase;
        fillPhase = ((i / 40) % 2) == 0;
        step(($urandom % 2) == 0, 8'($urandom), 3'($urandom),
             ($urandom % 4) == 0,
             fillPhase ? (($urandom % 8) == 0) : (($urandom % 4) != 0),
             ($urandom % 16) == 0, 0, 4'h0);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule